// File: doc/BRIEF.md
# Fractional-Rate Core Timer Counter

This block keeps a free-running 64-bit timer count whose pace is set by a 32-bit fractional rate value. One of two clock-enable inputs is chosen as the time base: a reference (crystal) enable or an alternate enable. Each pulse of the chosen enable adds the rate value to a phase accumulator. Whenever the accumulated phase reaches one whole unit (2^31), the block emits a one-cycle tick and advances the count by a step of either 1 or 2. The result is a tick rate of input rate × rate value / 2^31. A rate of 0x80000000 gives exactly one tick per input enable. A rate of 0 stops the timer.

Software configures the block through a small write-only port. The mode register at address 0x00 selects the time base and the step size. The rate register at address 0x08 holds the fractional rate. Writing 0 to the mode register selects the reference enable with a step of 1. Any accepted write restarts the phase from zero and leaves the count unchanged. Downstream logic reads the count value and the tick strobe directly from the outputs.

Top module: `tmr_frac_prescaler`

## Requirements
- R1: After synchronous reset, count is 0 and tick is 0, the mode register is 0 and the rate is 0. While the rate is 0, no input enable ever produces a tick.
- R2: With rate 0x80000000, every selected input enable sampled at a rising edge produces tick high in the following cycle. The count advances at that same edge.
- R3: For rates below 0x80000000, each selected enable adds the rate to a phase accumulator that starts from zero. A tick occurs on each enable where the sum reaches or passes 0x80000000, and the excess is kept. For example, rate 0x40000000 ticks on every 2nd enable, rate 0x20000000 on every 4th, and rate 0x60000000 on 3 of every 4.
- R4: Rates above 0x80000000 behave exactly as 0x80000000, giving one tick per selected enable and never more.
- R5: Mode bit 8 clear selects the reference enable (ref_en) and mode bit 8 set selects the alternate enable (alt_en). The unselected enable has no effect on tick or count.
- R6: Mode bit 9 clear makes each tick add 1 to count, and bit 9 set makes each tick add 2.
- R7: A write to address 0x00 or 0x08 takes effect from the next cycle. It clears the phase accumulator and produces no tick in its own cycle, even if an enable is present. The count keeps its value.
- R8: A write to any other address is ignored. It neither changes the configuration nor clears the phase, and counting proceeds as if no write occurred.
- R9: tick is high for exactly one cycle per tick event. count changes only in cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address (0x00 mode, 0x08 rate) |
| wr_data | input | 32 | Write data |
| ref_en | input | 1 | Reference time-base enable |
| alt_en | input | 1 | Alternate time-base enable |
| count | output | 64 | Timer count value |
| tick | output | 1 | One-cycle strobe marking a count advance |

## Verification
A corrupted phase accumulator shows first as a tick that appears one or more enables early or late against the fractional cadence. The bench predicts that cadence per enable and compares it every cycle, so the error is caught within one tick period. A wrong source or step selection appears at the first tick after the mode write, as a tick on the wrong enable or a count jump of the wrong size. A write that fails to clear the phase, or a foreign address that wrongly clears it, moves the next tick by at least one enable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 8;
    localparam int FRAC_W = 32;
    localparam int CNT_W  = 64;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_RATE = 8'h08;

    localparam int MODE_SRC_BIT  = 8;
    localparam int MODE_STEP_BIT = 9;

    typedef enum logic {
        SRC_REF = 1'b0,
        SRC_ALT = 1'b1
    } src_e;

    typedef enum logic {
        STEP_ONE = 1'b0,
        STEP_TWO = 1'b1
    } step_e;

    typedef struct packed {
        step_e step;
        src_e  src;
    } mode_t;

    localparam mode_t MODE_RESET = '{step: STEP_ONE, src: SRC_REF};

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [FW-1:0] wr_data,
    output mode_t         mode,
    output logic [FW-1:0] rate,
    output logic          cfg_wr
);

    logic hit_mode, hit_rate;

    always_comb begin
        hit_mode = wr_en && (wr_addr == AW'(ADDR_MODE));
        hit_rate = wr_en && (wr_addr == AW'(ADDR_RATE));
        cfg_wr   = hit_mode || hit_rate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
            rate <= '0;
        end else begin
            if (hit_mode) begin
                mode.src  <= src_e'(wr_data[MODE_SRC_BIT]);
                mode.step <= step_e'(wr_data[MODE_STEP_BIT]);
            end
            if (hit_rate) begin
                rate <= wr_data;
            end
        end
    end

    // R8: a write whose address matches neither register leaves configuration alone
    p_foreign_addr_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && !$past(hit_mode) && !$past(hit_rate))
        |-> ($stable(rate) && $stable(mode)));

endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_pkg::*;
(
    input  src_e src,
    input  logic ref_en,
    input  logic alt_en,
    output logic sel_en
);

    always_comb begin
        unique case (src)
            SRC_REF: sel_en = ref_en;
            SRC_ALT: sel_en = alt_en;
            default: sel_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_phase_acc.sv
module tmr_phase_acc #(
    parameter int FW = tmr_pkg::FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    input  logic [FW-1:0] rate,
    output logic          tick_now,
    output logic          tick_q
);

    localparam logic [FW-1:0] UNIT = FW'(1) << (FW-1);

    logic [FW-1:0] phase_q, phase_d;
    logic [FW-1:0] rate_c;
    logic [FW-1:0] sum;

    always_comb begin
        rate_c   = (rate > UNIT) ? UNIT : rate;
        sum      = phase_q + rate_c;
        tick_now = 1'b0;
        phase_d  = phase_q;
        if (clr) begin
            phase_d = '0;
        end else if (en) begin
            tick_now = sum[FW-1];
            phase_d  = {1'b0, sum[FW-2:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            tick_q  <= tick_now;
        end
    end

    // R3: the retained phase stays below one whole unit
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        phase_q < UNIT);

    // R7: an accepted write leaves the phase at zero
    p_clear_phase_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(clr)) |-> (phase_q == '0 && !tick_q));

    // R4: a rate at or above one unit ticks on every enable
    p_clamp_tick_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en) && !$past(clr) && $past(rate) >= UNIT) |-> tick_q);

    // R1: a zero rate never produces a tick
    p_stopped_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rate) == '0) |-> !tick_q);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  step_e         step,
    output logic [CW-1:0] count
);

    logic [CW-1:0] delta;

    always_comb begin
        delta = (step == STEP_TWO) ? CW'(2) : CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + delta;
        end
    end

endmodule

// File: rtl/tmr_frac_prescaler.sv
module tmr_frac_prescaler
    import tmr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int FW = FRAC_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [FW-1:0] wr_data,
    input  logic          ref_en,
    input  logic          alt_en,
    output logic [CW-1:0] count,
    output logic          tick
);

    mode_t         mode;
    logic [FW-1:0] rate;
    logic          cfg_wr;
    logic          sel_en;
    logic          tick_now;

    tmr_regs #(.AW(AW), .FW(FW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode    (mode),
        .rate    (rate),
        .cfg_wr  (cfg_wr)
    );

    tmr_src_sel u_src (
        .src    (mode.src),
        .ref_en (ref_en),
        .alt_en (alt_en),
        .sel_en (sel_en)
    );

    tmr_phase_acc #(.FW(FW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .en       (sel_en),
        .clr      (cfg_wr),
        .rate     (rate),
        .tick_now (tick_now),
        .tick_q   (tick)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (tick_now),
        .step  (mode.step),
        .count (count)
    );

    // R9: count holds whenever no tick is shown
    p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !tick) |-> $stable(count));

    // R6: a tick moves count by the selected step
    p_tick_step_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && tick) |->
        (count == $past(count) + (($past(mode.step) == STEP_TWO) ? CW'(2) : CW'(1))));

    // R5: a tick needs the selected enable in the previous cycle
    p_tick_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && tick) |-> $past(sel_en));

    // R7: no tick follows an accepted write
    p_no_tick_on_write_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cfg_wr)) |-> !tick);

endmodule

// File: tb/tb_tmr_frac_prescaler.sv
`timescale 1ns/1ps
module tb_tmr_frac_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ref_en = 1'b0;
    logic        alt_en = 1'b0;
    logic [63:0] count;
    logic        tick;

    always #2.5 clk = ~clk;

    tmr_frac_prescaler dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ref_en  (ref_en),
        .alt_en  (alt_en),
        .count   (count),
        .tick    (tick)
    );

    typedef struct {
        bit          tk;
        logic [63:0] cnt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // reference model state
    bit          m_src;
    bit          m_step;
    logic [31:0] m_rate;
    longint unsigned m_phase;
    logic [63:0] m_cnt;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic drive(input bit r, input bit a, input bit we,
                         input logic [7:0] ad, input logic [31:0] d, input string tag);
        exp_t e;
        bit   tk;
        bit   en;
        longint unsigned rr;
        @(negedge clk);
        ref_en = r; alt_en = a; wr_en = we; wr_addr = ad; wr_data = d;
        tk = 1'b0;
        if (we && (ad == 8'h00 || ad == 8'h08)) begin
            if (ad == 8'h00) begin
                m_src  = d[8];
                m_step = d[9];
            end else begin
                m_rate = d;
            end
            m_phase = 0;
        end else begin
            en = m_src ? a : r;
            if (en) begin
                rr = (m_rate > 32'h8000_0000) ? 64'h8000_0000 : longint'(m_rate);
                m_phase = m_phase + rr;
                if (m_phase >= 64'h8000_0000) begin
                    tk = 1'b1;
                    m_phase = m_phase - 64'h8000_0000;
                    m_cnt = m_cnt + (m_step ? 64'd2 : 64'd1);
                end
            end
        end
        @(posedge clk);
        #1;
        e.tk = tk; e.cnt = m_cnt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input bit r, input bit a, input string tag);
        drive(r, a, 1'b0, 8'h00, 32'h0, tag);
    endtask

    task automatic wr(input logic [7:0] ad, input logic [31:0] d, input bit r, input string tag);
        drive(r, 1'b0, 1'b1, ad, d, tag);
    endtask

    // monitor: compare outputs against queued predictions
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(tick == e.tk, e.tag, "tick", {63'd0, tick}, {63'd0, e.tk});
            check(count == e.cnt, e.tag, "count", count, e.cnt);
        end
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_src = 0; m_step = 0; m_rate = 0; m_phase = 0; m_cnt = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the outputs
        check(count == 64'd0, "R1", "reset count", count, 64'd0);
        check(tick == 1'b0, "R1", "reset tick", {63'd0, tick}, 64'd0);

        // R1: rate 0 after reset, enables produce nothing
        for (int i = 0; i < 6; i++) idle(1'b1, 1'b1, "R1 stopped");

        // R7: write with enable present gives no tick
        wr(8'h08, 32'h8000_0000, 1'b1, "R7 write cycle");
        // R2: one tick per enable
        for (int i = 0; i < 6; i++) idle(1'b1, 1'b0, "R2 unity continuous");
        for (int i = 0; i < 8; i++) idle(i[0], 1'b0, "R2 unity alternating");
        // R9: no enable, no change
        for (int i = 0; i < 3; i++) idle(1'b0, 1'b0, "R9 idle hold");

        // R6: step of two
        wr(8'h00, 32'h0000_0200, 1'b0, "R6 mode write");
        for (int i = 0; i < 5; i++) idle(1'b1, 1'b0, "R6 step two");
        wr(8'h00, 32'h0, 1'b0, "R6 back to step one");
        for (int i = 0; i < 3; i++) idle(1'b1, 1'b0, "R6 step one");

        // R3: fractional cadences
        wr(8'h08, 32'h4000_0000, 1'b0, "R3 half write");
        for (int i = 0; i < 8; i++) idle(1'b1, 1'b0, "R3 half");
        wr(8'h08, 32'h2000_0000, 1'b0, "R3 quarter write");
        for (int i = 0; i < 12; i++) idle((i % 3) != 2, 1'b0, "R3 quarter gapped");
        wr(8'h08, 32'h6000_0000, 1'b0, "R3 three quarter write");
        for (int i = 0; i < 12; i++) idle(1'b1, 1'b0, "R3 three quarter");
        wr(8'h08, 32'h0000_0001, 1'b0, "R3 tiny rate write");
        for (int i = 0; i < 4; i++) idle(1'b1, 1'b0, "R3 tiny rate");

        // R4: clamp above unity
        wr(8'h08, 32'hFFFF_FFFF, 1'b0, "R4 max rate write");
        for (int i = 0; i < 6; i++) idle(1'b1, 1'b0, "R4 clamp max");
        wr(8'h08, 32'h8000_0001, 1'b0, "R4 just above write");
        for (int i = 0; i < 6; i++) idle(i != 2, 1'b0, "R4 clamp just above");

        // R5: alternate source, reference ignored
        wr(8'h00, 32'h0000_0100, 1'b0, "R5 alt select");
        for (int i = 0; i < 4; i++) idle(1'b1, 1'b0, "R5 ref ignored");
        for (int i = 0; i < 6; i++) idle(1'b0, i[0], "R5 alt drives");
        wr(8'h00, 32'h0000_0300, 1'b0, "R5 alt with step two");
        for (int i = 0; i < 4; i++) idle(1'b0, 1'b1, "R5 alt step two");
        wr(8'h00, 32'h0, 1'b0, "R5 zero mode ref");
        for (int i = 0; i < 4; i++) idle(1'b0, 1'b1, "R5 alt ignored");
        for (int i = 0; i < 2; i++) idle(1'b1, 1'b0, "R5 ref drives");

        // R8: foreign address keeps phase and configuration
        wr(8'h08, 32'h4000_0000, 1'b0, "R8 half write");
        idle(1'b1, 1'b0, "R8 half phase");
        wr(8'h04, 32'h0000_0300, 1'b1, "R8 foreign write counts");
        idle(1'b1, 1'b0, "R8 phase kept");
        wr(8'h0C, 32'h0, 1'b0, "R8 foreign write 0C");
        for (int i = 0; i < 4; i++) idle(1'b1, 1'b0, "R8 config kept");

        // R7: accepted write drops a half phase
        idle(1'b1, 1'b0, "R7 build phase");
        wr(8'h08, 32'h4000_0000, 1'b1, "R7 clearing write");
        for (int i = 0; i < 4; i++) idle(1'b1, 1'b0, "R7 after clear");

        // R1: zero rate stops again, count held
        wr(8'h08, 32'h0, 1'b0, "R1 stop write");
        for (int i = 0; i < 4; i++) idle(1'b1, 1'b1, "R1 stopped again");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule